// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM Core

This block is a single-port synchronous memory with registered address, control and data paths and one output pipeline stage. A cycle can be opened by either of two active-low address strobes: a processor-side strobe that always starts a read, and a controller-side strobe that starts a read or a write chosen by the write enables on that edge. Three chip selects qualify every start. Once a cycle is open, later edges either advance to the next address of a four-beat burst or hold the present address, and each of those edges is a read or a write depending on the write enables sampled there.

Words are 18 bits wide and split into two 9-bit lanes. A write can cover both lanes at once, or only the lanes chosen by per-lane enables. The tri-state data bus is modelled as separate write-data, read-data and drive-enable ports. A level-sensitive output enable gates the drive-enable. The array is a plain register array whose depth is a parameter.

Top module: `burst_sram_core`

## Requirements
- R1: The block is selected only when sel0_n=0, sel1=1 and sel2_n=0. A start made with any other combination deselects it: no memory write happens, and rdata_oe is low after the second rising edge that follows.
- R2: proc_strobe_n low with sel0_n low on an edge loads addr and starts a read, whatever ctrl_strobe_n and the write enables are. Memory is left unchanged on that edge.
- R3: With sel0_n high, proc_strobe_n is ignored. If ctrl_strobe_n is also high, the open cycle continues or holds under advance_n exactly as if proc_strobe_n were high.
- R4: ctrl_strobe_n low starts a cycle only when the processor strobe is high or blocked by sel0_n. The write enables on that edge pick write or read, and with sel0_n high it deselects.
- R5: With both strobes high on an open cycle, advance_n low steps to the next burst address. Only addr[1:0] changes, and it wraps in groups of four. With BURST_LINEAR=0 the k-th beat is start^k; with BURST_LINEAR=1 it is start+k modulo 4.
- R6: With both strobes high on an open cycle, advance_n high keeps the current address. The edge is a write if the write enables request one, and a read otherwise.
- R7: wr_all_n=0 writes both lanes. Otherwise, wr_byte_n=0 writes each lane i whose byte_wr_n[i]=0, where lane 0 is wdata[8:0] and lane 1 is wdata[17:9]. Any other combination is a read.
- R8: Data for a read sampled on rising edge k is on rdata after edge k+1, with rdata_oe high when out_en_n is low.
- R9: out_en_n high forces rdata_oe low at once, without waiting for a clock edge.
- R10: A write is captured on the edge that samples it, and rdata_oe is low after that edge.
- R11: A read on the edge after a write to the same address returns the newly written data.
- R12: After reset the block is deselected and rdata_oe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of control state |
| sel0_n | input | 1 | Master select, active low; also gates the processor strobe |
| sel1 | input | 1 | Select, active high |
| sel2_n | input | 1 | Select, active low |
| proc_strobe_n | input | 1 | Processor address strobe, active low |
| ctrl_strobe_n | input | 1 | Controller address strobe, active low |
| advance_n | input | 1 | Burst advance, active low |
| wr_all_n | input | 1 | Write of both lanes, active low |
| wr_byte_n | input | 1 | Enables per-lane writes, active low |
| byte_wr_n | input | BYTES | Per-lane write enables, active low |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| addr | input | log2(DEPTH) | Word address |
| wdata | input | BYTE_W*BYTES | Write data |
| rdata | output | BYTE_W*BYTES | Registered read data |
| rdata_oe | output | 1 | Drive enable for the read data bus |

## Verification
The bench builds two copies with DEPTH=32. Both share every input, and they differ only in BURST_LINEAR. With the small depth, every burst group and every address is reachable in a few cycles. With the two burst orders side by side, a single read burst exposes both address sequences and the wrap back to the start beat. Everything else runs at the default 9-bit, two-lane word, so all lane-enable combinations are covered.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;

  localparam int BURST_BITS = 2;

  typedef enum logic [2:0] {
    OP_IDLE,
    OP_DESEL,
    OP_RD_NEW,
    OP_WR_NEW,
    OP_RD_ADV,
    OP_WR_ADV,
    OP_RD_HOLD,
    OP_WR_HOLD
  } cyc_op_e;

  // beat offset within a burst group for a given start and beat count
  function automatic logic [BURST_BITS-1:0] burst_offset(
    input logic [BURST_BITS-1:0] start,
    input logic [BURST_BITS-1:0] beat,
    input logic                  linear
  );
    return linear ? (start + beat) : (start ^ beat);
  endfunction

endpackage

// File: rtl/sram_cycle_decode.sv
module sram_cycle_decode
  import burst_sram_pkg::*;
#(
  parameter int NB = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          open_q,
  input  logic          sel0_n,
  input  logic          sel1,
  input  logic          sel2_n,
  input  logic          proc_strobe_n,
  input  logic          ctrl_strobe_n,
  input  logic          advance_n,
  input  logic          wr_all_n,
  input  logic          wr_byte_n,
  input  logic [NB-1:0] byte_wr_n,
  output cyc_op_e       op,
  output logic [NB-1:0] lane_we,
  output logic          load,
  output logic          step,
  output logic          rd_cyc,
  output logic          wr_cyc
);

  logic          sel_ok;
  logic          p_start;
  logic          c_start;
  logic [NB-1:0] req_mask;
  logic          wr_req;

  always_comb begin
    sel_ok  = !sel0_n && sel1 && !sel2_n;
    p_start = !proc_strobe_n && !sel0_n;
    c_start = !ctrl_strobe_n && !p_start;
    for (int i = 0; i < NB; i++) begin
      req_mask[i] = !wr_all_n || (!wr_byte_n && !byte_wr_n[i]);
    end
    wr_req = |req_mask;

    if (p_start)        op = sel_ok ? OP_RD_NEW : OP_DESEL;
    else if (c_start)   op = !sel_ok ? OP_DESEL : (wr_req ? OP_WR_NEW : OP_RD_NEW);
    else if (open_q) begin
      if (!advance_n)   op = wr_req ? OP_WR_ADV : OP_RD_ADV;
      else              op = wr_req ? OP_WR_HOLD : OP_RD_HOLD;
    end
    else                op = OP_IDLE;

    load    = (op == OP_RD_NEW) || (op == OP_WR_NEW);
    step    = (op == OP_RD_ADV) || (op == OP_WR_ADV);
    wr_cyc  = (op == OP_WR_NEW) || (op == OP_WR_ADV) || (op == OP_WR_HOLD);
    rd_cyc  = (op == OP_RD_NEW) || (op == OP_RD_ADV) || (op == OP_RD_HOLD);
    lane_we = wr_cyc ? req_mask : '0;
  end

  // R7: a global write enable always reaches every lane
  p_global_lanes_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cyc && !wr_all_n) |-> (&lane_we));

endmodule

// File: rtl/sram_burst_addr.sv
module sram_burst_addr
  import burst_sram_pkg::*;
#(
  parameter int AW     = 8,
  parameter bit LINEAR = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic [AW-1:0] ext_addr,
  output logic [AW-1:0] cyc_addr
);

  localparam int BB = BURST_BITS;

  logic [AW-1:0] addr_q;
  logic [BB-1:0] base_q;
  logic [BB-1:0] beat_q;
  logic [BB-1:0] beat_nx;
  logic [AW-1:0] adv_addr;

  always_comb begin
    beat_nx  = beat_q + BB'(1);
    adv_addr = {addr_q[AW-1:BB], burst_offset(base_q, beat_nx, LINEAR)};
    if (load)      cyc_addr = ext_addr;
    else if (step) cyc_addr = adv_addr;
    else           cyc_addr = addr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      base_q <= '0;
      beat_q <= '0;
    end else if (load) begin
      addr_q <= ext_addr;
      base_q <= ext_addr[BB-1:0];
      beat_q <= '0;
    end else if (step) begin
      addr_q <= adv_addr;
      beat_q <= beat_nx;
    end
  end

  // R6: without load or step the held address does not move
  p_hold_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !step) |=> $stable(addr_q));

  // R5: a burst step never leaves its group of four
  p_step_in_group_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> $stable(addr_q[AW-1:BB]));

endmodule

// File: rtl/sram_store.sv
module sram_store #(
  parameter int DEPTH = 256,
  parameter int AW    = 8,
  parameter int BW    = 9,
  parameter int NB    = 2,
  localparam int WW   = BW * NB
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] cyc_addr,
  input  logic [NB-1:0] lane_we,
  input  logic [WW-1:0] wdata,
  input  logic          rd_cyc,
  input  logic          wr_cyc,
  output logic [WW-1:0] rdata,
  output logic          drive
);

  logic [WW-1:0] mem [DEPTH];
  logic [AW-1:0] rd_addr_q;
  logic          rd_pend_q;
  logic [WW-1:0] dout_q;
  logic          drive_q;

  always_ff @(posedge clk) begin
    for (int i = 0; i < NB; i++) begin
      if (lane_we[i]) mem[cyc_addr][i*BW +: BW] <= wdata[i*BW +: BW];
    end
  end

  always_ff @(posedge clk) begin
    if (rd_cyc)    rd_addr_q <= cyc_addr;
    if (rd_pend_q) dout_q    <= mem[rd_addr_q];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_pend_q <= 1'b0;
      drive_q   <= 1'b0;
    end else begin
      rd_pend_q <= rd_cyc;
      drive_q   <= rd_pend_q && !wr_cyc;
    end
  end

  assign rdata = dout_q;
  assign drive = drive_q;

  // R10: a write edge mutes the drivers right after it
  p_write_mutes_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cyc |=> !drive);

  // R8: a read followed by a non-write edge is driven one edge later
  p_read_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cyc ##1 !wr_cyc |=> drive);

endmodule

// File: rtl/burst_sram_core.sv
module burst_sram_core
  import burst_sram_pkg::*;
#(
  parameter int  DEPTH        = 256,
  parameter int  BYTE_W       = 9,
  parameter int  BYTES        = 2,
  parameter bit  BURST_LINEAR = 1'b0,
  localparam int ADDR_W       = $clog2(DEPTH),
  localparam int WORD_W       = BYTE_W * BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel0_n,
  input  logic              sel1,
  input  logic              sel2_n,
  input  logic              proc_strobe_n,
  input  logic              ctrl_strobe_n,
  input  logic              advance_n,
  input  logic              wr_all_n,
  input  logic              wr_byte_n,
  input  logic [BYTES-1:0]  byte_wr_n,
  input  logic              out_en_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata,
  output logic              rdata_oe
);

  cyc_op_e           op;
  logic [BYTES-1:0]  lane_we;
  logic              load;
  logic              step;
  logic              rd_cyc;
  logic              wr_cyc;
  logic              open_q;
  logic [ADDR_W-1:0] cyc_addr;
  logic              drive;

  sram_cycle_decode #(.NB(BYTES)) u_decode (
    .clk           (clk),
    .rst_n         (rst_n),
    .open_q        (open_q),
    .sel0_n        (sel0_n),
    .sel1          (sel1),
    .sel2_n        (sel2_n),
    .proc_strobe_n (proc_strobe_n),
    .ctrl_strobe_n (ctrl_strobe_n),
    .advance_n     (advance_n),
    .wr_all_n      (wr_all_n),
    .wr_byte_n     (wr_byte_n),
    .byte_wr_n     (byte_wr_n),
    .op            (op),
    .lane_we       (lane_we),
    .load          (load),
    .step          (step),
    .rd_cyc        (rd_cyc),
    .wr_cyc        (wr_cyc)
  );

  sram_burst_addr #(.AW(ADDR_W), .LINEAR(BURST_LINEAR)) u_burst (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .step     (step),
    .ext_addr (addr),
    .cyc_addr (cyc_addr)
  );

  sram_store #(.DEPTH(DEPTH), .AW(ADDR_W), .BW(BYTE_W), .NB(BYTES)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .cyc_addr (cyc_addr),
    .lane_we  (lane_we),
    .wdata    (wdata),
    .rd_cyc   (rd_cyc),
    .wr_cyc   (wr_cyc),
    .rdata    (rdata),
    .drive    (drive)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              open_q <= 1'b0;
    else if (op == OP_DESEL) open_q <= 1'b0;
    else if (load)           open_q <= 1'b1;
  end

  assign rdata_oe = drive && !out_en_n;

  // R1: a deselecting start leaves the bus undriven two edges on
  p_desel_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_DESEL) |=> ##1 !drive);

  // R2: a processor start never writes the array
  p_proc_no_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!proc_strobe_n && !sel0_n) |-> (lane_we == '0));

  // R3: a blocked processor strobe loads no address
  p_proc_blocked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!proc_strobe_n && sel0_n && ctrl_strobe_n) |-> !load);

  // R4: a controller start with the master select high deselects
  p_ctrl_desel_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_strobe_n && sel0_n) |=> !open_q);

endmodule

// File: tb/tb_burst_sram_core.sv
module tb_burst_sram_core;

  localparam int DEPTH = 32;
  localparam int AW    = $clog2(DEPTH);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sel0_n, sel1, sel2_n;
  logic          proc_strobe_n, ctrl_strobe_n, advance_n;
  logic          wr_all_n, wr_byte_n;
  logic [1:0]    byte_wr_n;
  logic          out_en_n;
  logic [AW-1:0] addr;
  logic [17:0]   wdata;
  logic [17:0]   rdata, rdata_l;
  logic          rdata_oe, rdata_oe_l;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  burst_sram_core #(.DEPTH(DEPTH), .BURST_LINEAR(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .sel0_n(sel0_n), .sel1(sel1), .sel2_n(sel2_n),
    .proc_strobe_n(proc_strobe_n), .ctrl_strobe_n(ctrl_strobe_n),
    .advance_n(advance_n), .wr_all_n(wr_all_n), .wr_byte_n(wr_byte_n),
    .byte_wr_n(byte_wr_n), .out_en_n(out_en_n), .addr(addr), .wdata(wdata),
    .rdata(rdata), .rdata_oe(rdata_oe));

  burst_sram_core #(.DEPTH(DEPTH), .BURST_LINEAR(1'b1)) dut_lin (
    .clk(clk), .rst_n(rst_n), .sel0_n(sel0_n), .sel1(sel1), .sel2_n(sel2_n),
    .proc_strobe_n(proc_strobe_n), .ctrl_strobe_n(ctrl_strobe_n),
    .advance_n(advance_n), .wr_all_n(wr_all_n), .wr_byte_n(wr_byte_n),
    .byte_wr_n(byte_wr_n), .out_en_n(out_en_n), .addr(addr), .wdata(wdata),
    .rdata(rdata_l), .rdata_oe(rdata_oe_l));

  task automatic chk(input string req, input logic [17:0] act, input logic [17:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle_in;
    sel0_n = 1'b0; sel1 = 1'b1; sel2_n = 1'b0;
    proc_strobe_n = 1'b1; ctrl_strobe_n = 1'b1; advance_n = 1'b1;
    wr_all_n = 1'b1; wr_byte_n = 1'b1; byte_wr_n = 2'b11;
  endtask

  task automatic desel;
    idle_in();
    ctrl_strobe_n = 1'b0; sel0_n = 1'b1;
    tick();
    idle_in();
    sel0_n = 1'b1;
  endtask

  task automatic wr_word(input logic [AW-1:0] a, input logic [17:0] d,
                         input logic all_n, input logic byt_n, input logic [1:0] lanes_n);
    idle_in();
    ctrl_strobe_n = 1'b0; addr = a; wdata = d;
    wr_all_n = all_n; wr_byte_n = byt_n; byte_wr_n = lanes_n;
    tick();
    desel();
  endtask

  task automatic rd_word(input logic [AW-1:0] a, output logic [17:0] d, output logic oe);
    idle_in();
    ctrl_strobe_n = 1'b0; addr = a;
    tick();
    idle_in();
    tick();
    d  = rdata;
    oe = rdata_oe;
    desel();
  endtask

  task automatic t_reset;
    chk("R12 oe after reset", 18'(rdata_oe), 18'd0);
    tick();
    chk("R12 oe idle after reset", 18'(rdata_oe), 18'd0);
  endtask

  task automatic t_write_read;
    logic [17:0] d; logic oe;
    wr_word(5'd3, 18'h2A5A5, 1'b0, 1'b1, 2'b11);
    rd_word(5'd3, d, oe);
    chk("R8 read data", d, 18'h2A5A5);
    chk("R8 read drives", 18'(oe), 18'd1);
  endtask

  task automatic t_lanes;
    logic [17:0] d; logic oe;
    wr_word(5'd4, 18'h3FFFF, 1'b0, 1'b1, 2'b11);
    wr_word(5'd4, 18'h00000, 1'b1, 1'b0, 2'b10);
    rd_word(5'd4, d, oe);
    chk("R7 lane0 only", d, 18'h3FE00);
    wr_word(5'd4, 18'h00000, 1'b1, 1'b0, 2'b01);
    rd_word(5'd4, d, oe);
    chk("R7 lane1 only", d, 18'h00000);
    wr_word(5'd4, 18'h15555, 1'b1, 1'b1, 2'b00);
    rd_word(5'd4, d, oe);
    chk("R7 lanes without byte enable", d, 18'h00000);
    wr_word(5'd4, 18'h12345, 1'b0, 1'b1, 2'b11);
    rd_word(5'd4, d, oe);
    chk("R7 global overrides", d, 18'h12345);
  endtask

  task automatic t_proc_read;
    logic [17:0] d; logic oe;
    wr_word(5'd6, 18'h0AAAA, 1'b0, 1'b1, 2'b11);
    idle_in();
    proc_strobe_n = 1'b0; ctrl_strobe_n = 1'b0; wr_all_n = 1'b0;
    addr = 5'd6; wdata = 18'h3FFFF;
    tick();
    idle_in();
    tick();
    chk("R2 proc start reads", rdata, 18'h0AAAA);
    chk("R2 proc start drives", 18'(rdata_oe), 18'd1);
    desel();
    rd_word(5'd6, d, oe);
    chk("R2 memory unchanged", d, 18'h0AAAA);
  endtask

  task automatic t_ce0_block;
    wr_word(5'd7, 18'h11111, 1'b0, 1'b1, 2'b11);
    wr_word(5'd9, 18'h22222, 1'b0, 1'b1, 2'b11);
    idle_in();
    ctrl_strobe_n = 1'b0; addr = 5'd7;
    tick();
    idle_in();
    proc_strobe_n = 1'b0; sel0_n = 1'b1; addr = 5'd9;
    tick();
    chk("R8 first beat", rdata, 18'h11111);
    idle_in();
    tick();
    chk("R3 blocked strobe holds address", rdata, 18'h11111);
    chk("R6 hold keeps reading", 18'(rdata_oe), 18'd1);
    desel();
  endtask

  task automatic t_deselect;
    desel();
    idle_in();
    ctrl_strobe_n = 1'b0; sel1 = 1'b0; addr = 5'd7;
    tick();
    idle_in();
    tick();
    chk("R1 sel1 low deselects", 18'(rdata_oe), 18'd0);
    idle_in();
    proc_strobe_n = 1'b0; sel2_n = 1'b1; addr = 5'd7;
    tick();
    idle_in();
    tick();
    chk("R1 sel2_n high deselects", 18'(rdata_oe), 18'd0);
    idle_in();
    ctrl_strobe_n = 1'b0; addr = 5'd7;
    tick();
    idle_in();
    proc_strobe_n = 1'b0; ctrl_strobe_n = 1'b0; sel0_n = 1'b1;
    tick();
    chk("R4 pending read still shown", rdata, 18'h11111);
    idle_in();
    tick();
    chk("R4 controller start with sel0_n high", 18'(rdata_oe), 18'd0);
    desel();
  endtask

  task automatic t_burst_read;
    logic [17:0] exp_i [5];
    logic [17:0] exp_l [5];
    for (int i = 0; i < 4; i++) wr_word(AW'(8 + i), 18'h00100 + 18'(i), 1'b0, 1'b1, 2'b11);
    exp_i = '{18'h00101, 18'h00100, 18'h00103, 18'h00102, 18'h00101};
    exp_l = '{18'h00101, 18'h00102, 18'h00103, 18'h00100, 18'h00101};
    idle_in();
    ctrl_strobe_n = 1'b0; addr = 5'd9;
    tick();
    idle_in();
    advance_n = 1'b0;
    for (int k = 0; k < 5; k++) begin
      if (k == 4) advance_n = 1'b1;
      tick();
      chk("R5 interleaved beat", rdata, exp_i[k]);
      chk("R5 linear beat", rdata_l, exp_l[k]);
    end
    desel();
  endtask

  task automatic t_burst_write;
    logic [17:0] d; logic oe;
    idle_in();
    ctrl_strobe_n = 1'b0; addr = 5'd16; wdata = 18'h01600; wr_all_n = 1'b0;
    tick();
    idle_in();
    advance_n = 1'b0; wr_all_n = 1'b0; wdata = 18'h01711;
    tick();
    idle_in();
    wr_all_n = 1'b0; wdata = 18'h01722;
    tick();
    desel();
    rd_word(5'd17, d, oe);
    chk("R6 held write overwrites", d, 18'h01722);
    rd_word(5'd16, d, oe);
    chk("R5 burst write start beat", d, 18'h01600);
  endtask

  task automatic t_out_enable;
    wr_word(5'd12, 18'h0BEEF, 1'b0, 1'b1, 2'b11);
    idle_in();
    ctrl_strobe_n = 1'b0; addr = 5'd12;
    tick();
    idle_in();
    tick();
    chk("R8 oe low drives", 18'(rdata_oe), 18'd1);
    out_en_n = 1'b1;
    #1;
    chk("R9 oe high mutes", 18'(rdata_oe), 18'd0);
    out_en_n = 1'b0;
    #1;
    chk("R9 oe low restores", 18'(rdata_oe), 18'd1);
    wr_all_n = 1'b0; wdata = 18'h00ABC;
    tick();
    chk("R10 write mutes", 18'(rdata_oe), 18'd0);
    idle_in();
    tick();
    chk("R10 no pending read", 18'(rdata_oe), 18'd0);
    tick();
    chk("R10 held write stored", rdata, 18'h00ABC);
    desel();
  endtask

  task automatic t_read_after_write;
    wr_word(5'd13, 18'h00000, 1'b0, 1'b1, 2'b11);
    idle_in();
    ctrl_strobe_n = 1'b0; addr = 5'd13; wdata = 18'h2D2D2; wr_all_n = 1'b0;
    tick();
    idle_in();
    ctrl_strobe_n = 1'b0; addr = 5'd13;
    tick();
    idle_in();
    tick();
    chk("R11 read after write", rdata, 18'h2D2D2);
    desel();
  endtask

  task automatic finish_run;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    idle_in();
    out_en_n = 1'b0;
    addr = '0;
    wdata = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_write_read();
    t_lanes();
    t_proc_read();
    t_ce0_block();
    t_deselect();
    t_burst_read();
    t_burst_write();
    t_out_enable();
    t_read_after_write();
    done = 1'b1;
    finish_run();
  end

endmodule